// File: doc/BRIEF.md
# Nibble-Serial Word-Block CRC-16 Generator

This block computes a 16-bit check value over a block of 32-bit words. A one-cycle `start` pulse loads the block length in words and clears the running check value to zero. Words then arrive on a valid/ready stream, and each accepted word is folded into the check value four bits at a time, starting with the most significant nibble.

A build parameter chooses how each word is folded. In the default variant all eight nibble steps are unrolled, so one word is taken per cycle. In the serial variant one nibble is taken per cycle, so each word occupies eight cycles and `inReady` is low while it is being folded.

When the last word has been folded, `done` pulses for one cycle. The final check value is then held, together with a header word that carries the block length and the check value. Both stay unchanged until the next `start`.

Top module: `nibcrc_top`

## Requirements
- R1: A `start` pulse latches `wordCount` and clears the check value. In the cycle after `start`, `crcOut` reads 0x0000 and, for a nonzero count, `done` is low.
- R2: Each accepted word is consumed as eight 4-bit nibbles in order: bits 31:28 first and bits 3:0 last.
- R3: Each nibble step forms s = crc[15:12] XOR nibble. The new value is ((crc << 4) XOR (s << 12) XOR (s << 5) XOR s), truncated to 16 bits.
- R4: `headerOut` carries the latched word count in bits 31:16 and the check value in bits 15:0.
- R5: A word count of zero makes `done` high in the cycle after `start`, with `crcOut` equal to 0x0000.
- R6: `done` is high for exactly one cycle once the final word has been folded. In the default unrolled variant, this is the cycle after the clock edge that accepts the last word.
- R7: Once the block completes, `inReady` stays low and `crcOut` and `headerOut` hold their values until the next `start`. Words offered in that interval are ignored.
- R8: A `start` that arrives in the middle of a block abandons that block, and the new block's result depends only on its own words.
- R9: Only cycles with both `inValid` and `inReady` high consume a word. Idle cycles inside a block do not change the result.
- R10: A block of 0x3F1 words, the fixed length of a speed-map image, completes with the header length field equal to 0x03F1.
- R11: After reset, `done` and `inReady` are low and `crcOut` and `headerOut` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that opens a new block |
| wordCount | input | CNT_W | Block length in words, sampled with `start` |
| inValid | input | 1 | Input word is valid |
| inData | input | 32 | Input word |
| inReady | output | 1 | Block can take a word this cycle |
| done | output | 1 | One-cycle pulse when the block completes |
| crcOut | output | 16 | Running, then final, check value |
| headerOut | output | CNT_W+16 | Length in the upper field, check value in the lower field |

## Verification
The bench goes after nibble order and the update polynomial. A design that folds the low nibble first, or drops the shift-by-five term, yields a different check value on every multi-word vector. It sends blocks of one word, several words and 0x3F1 words, with and without idle gaps. A design that counts idle cycles as words would finish early, and one that misses the final word would never raise `done`. It also covers the zero-length block, extra words offered after completion, and a restart in the middle of a block. These catch a design that skips the empty-block pulse, keeps absorbing words while idle, or carries the check value over from an abandoned block.

// File: rtl/nibcrc_pkg.sv
package nibcrc_pkg;
  localparam int WORD_W = 32;
  localparam int CRC_W = 16;
  localparam int NIB_W = 4;
  localparam int NIBS = WORD_W / NIB_W;
  localparam int STEP_W = $clog2(NIBS);

  typedef struct packed {
    logic clear;
    logic load;
    logic step;
    logic finish;
  } crcCtl_t;

  function automatic logic [CRC_W-1:0] nibStep(input logic [CRC_W-1:0] c, input logic [NIB_W-1:0] n);
    logic [NIB_W-1:0] s;
    s = c[CRC_W-1 -: NIB_W] ^ n;
    return {c[CRC_W-NIB_W-1:0], 4'h0} ^ {s, 12'h000} ^ {7'h00, s, 5'h00} ^ {12'h000, s};
  endfunction

  function automatic logic [CRC_W-1:0] foldWord(input logic [CRC_W-1:0] c, input logic [WORD_W-1:0] w);
    logic [CRC_W-1:0] acc;
    acc = c;
    for (int i = NIBS - 1; i >= 0; i--) begin
      acc = nibStep(acc, w[i*NIB_W +: NIB_W]);
    end
    return acc;
  endfunction
endpackage

// File: rtl/nibcrc_ctrl.sv
module nibcrc_ctrl
  import nibcrc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter bit SERIAL = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] wordCount,
  input  logic             inValid,
  output logic             inReady,
  output logic             done,
  output crcCtl_t          ctl
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NIBS - 1);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  typedef enum logic [1:0] {IDLE, RUN, FOLD} state_t;
  state_t state;
  logic [CNT_W-1:0] remaining;
  logic [STEP_W-1:0] stepCnt;
  logic accept;

  assign inReady = (state == RUN) && !start;
  assign accept = inValid && inReady;

  always_comb begin
    ctl = '0;
    if (start) begin
      ctl.clear = 1'b1;
      ctl.finish = (wordCount == '0);
    end else begin
      case (state)
        RUN: if (accept) begin
          ctl.load = 1'b1;
          ctl.finish = !SERIAL && (remaining == ONE);
        end
        FOLD: begin
          ctl.step = 1'b1;
          ctl.finish = (stepCnt == LAST_STEP) && (remaining == ONE);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= IDLE;
      remaining <= '0;
      stepCnt <= '0;
      done <= 1'b0;
    end else begin
      done <= ctl.finish;
      if (start) begin
        remaining <= wordCount;
        stepCnt <= '0;
        state <= (wordCount == '0) ? IDLE : RUN;
      end else begin
        case (state)
          RUN: if (accept) begin
            if (SERIAL) begin
              state <= FOLD;
              stepCnt <= '0;
            end else begin
              remaining <= remaining - ONE;
              if (remaining == ONE) state <= IDLE;
            end
          end
          FOLD: begin
            stepCnt <= stepCnt + 1'b1;
            if (stepCnt == LAST_STEP) begin
              remaining <= remaining - ONE;
              state <= (remaining == ONE) ? IDLE : RUN;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/nibcrc_datapath.sv
module nibcrc_datapath
  import nibcrc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter bit SERIAL = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcCtl_t           ctl,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic [WORD_W-1:0] inData,
  output logic [CRC_W-1:0]  crcQ,
  output logic [CNT_W-1:0]  countQ
);
  always_ff @(posedge clk) begin
    if (!rstN) countQ <= '0;
    else if (ctl.clear) countQ <= wordCount;
  end

  generate
    if (SERIAL) begin : g_serial
      logic [WORD_W-1:0] shiftQ;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          crcQ <= '0;
          shiftQ <= '0;
        end else if (ctl.clear) begin
          crcQ <= '0;
        end else if (ctl.load) begin
          shiftQ <= inData;
        end else if (ctl.step) begin
          crcQ <= nibStep(crcQ, shiftQ[WORD_W-1 -: NIB_W]);
          shiftQ <= {shiftQ[WORD_W-NIB_W-1:0], {NIB_W{1'b0}}};
        end
      end
    end else begin : g_unrolled
      always_ff @(posedge clk) begin
        if (!rstN) crcQ <= '0;
        else if (ctl.clear) crcQ <= '0;
        else if (ctl.load) crcQ <= foldWord(crcQ, inData);
      end
    end
  endgenerate
endmodule

// File: rtl/nibcrc_top.sv
module nibcrc_top
  import nibcrc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter bit SERIAL = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [CNT_W-1:0]       wordCount,
  input  logic                   inValid,
  input  logic [WORD_W-1:0]      inData,
  output logic                   inReady,
  output logic                   done,
  output logic [CRC_W-1:0]       crcOut,
  output logic [CNT_W+CRC_W-1:0] headerOut
);
  crcCtl_t ctl;
  logic [CNT_W-1:0] countQ;

  nibcrc_ctrl #(.CNT_W(CNT_W), .SERIAL(SERIAL)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .wordCount(wordCount),
    .inValid(inValid), .inReady(inReady), .done(done), .ctl(ctl)
  );

  nibcrc_datapath #(.CNT_W(CNT_W), .SERIAL(SERIAL)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordCount(wordCount),
    .inData(inData), .crcQ(crcOut), .countQ(countQ)
  );

  assign headerOut = {countQ, crcOut};
endmodule

// File: rtl/nibcrc_chk.sv
module nibcrc_chk
  import nibcrc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   start,
  input logic [CNT_W-1:0]       wordCount,
  input logic                   inReady,
  input logic                   done,
  input logic [CRC_W-1:0]       crcOut,
  input logic [CNT_W+CRC_W-1:0] headerOut
);
  logic idleQ;

  always_ff @(posedge clk) begin
    if (!rstN) idleQ <= 1'b1;
    else if (start) idleQ <= 1'b0;
    else if (done) idleQ <= 1'b1;
  end

  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    (start && wordCount != '0) |=> (crcOut == '0 && !done)); // R1
  AST_EMPTY_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (start && wordCount == '0) |=> (done && crcOut == '0)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> !done); // R6
  AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (idleQ && !start) |-> !inReady); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (idleQ && !start) |=> ($stable(crcOut) && $stable(headerOut))); // R7
endmodule

bind nibcrc_top nibcrc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .wordCount(wordCount),
  .inReady(inReady), .done(done), .crcOut(crcOut), .headerOut(headerOut)
);

// File: tb/sim_nibcrc_top.sv
module sim_nibcrc_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [15:0] wordCount = '0;
  logic inValid = 1'b0;
  logic [31:0] inData = '0;
  logic inReady, done;
  logic [15:0] crcOut;
  logic [31:0] headerOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  nibcrc_top u0 (
    .clk(clk), .rstN(rstN), .start(start), .wordCount(wordCount),
    .inValid(inValid), .inData(inData), .inReady(inReady), .done(done),
    .crcOut(crcOut), .headerOut(headerOut)
  );

  localparam int NV = 5;
  localparam logic [15:0] VEC_CNT [NV] = '{16'd1, 16'd2, 16'd7, 16'd16, 16'd3};
  localparam logic [31:0] VEC_BASE [NV] = '{32'h8000_0001, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0000_0000, 32'hF00F_0FF0};
  localparam bit VEC_GAP [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

  function automatic logic [15:0] refNib(input logic [15:0] c, input logic [3:0] n);
    logic [3:0] s;
    logic [31:0] t;
    s = (c >> 12) ^ n;
    t = (32'(c) << 4) ^ (32'(s) << 12) ^ (32'(s) << 5) ^ 32'(s);
    return t[15:0];
  endfunction

  function automatic logic [15:0] refWord(input logic [15:0] c, input logic [31:0] w);
    logic [15:0] a;
    a = c;
    for (int sh = 28; sh >= 0; sh -= 4) a = refNib(a, 4'((w >> sh) & 32'hF));
    return a;
  endfunction

  function automatic logic [31:0] genWord(input logic [31:0] base, input int i);
    return base ^ (32'(i) * 32'h9E37_79B9) ^ (32'(i) << 7);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  logic [15:0] lastExp;

  task automatic runBlock(input logic [15:0] cnt, input logic [31:0] base, input bit gaps, input string req);
    logic [15:0] exp;
    int sent;
    int k;
    int w;
    exp = '0;
    sent = 0;
    k = 0;
    @(negedge clk);
    start = 1'b1;
    wordCount = cnt;
    @(negedge clk);
    start = 1'b0;
    check(crcOut == 16'h0 && !done, "R1", "cleared after start", {16'h0, crcOut}, 32'h0);
    while (sent < int'(cnt)) begin
      if (gaps && (k % 2 == 1)) begin
        inValid = 1'b0;
        inData = 32'hBAD0_BAD0;
      end else begin
        inValid = 1'b1;
        inData = genWord(base, sent);
      end
      #0.1;
      if (inValid && inReady) begin
        exp = refWord(exp, inData);
        sent++;
      end
      k++;
      @(negedge clk);
    end
    inValid = 1'b0;
    w = 0;
    while (!done && w < 20) begin
      @(negedge clk);
      w++;
    end
    check(done && w == 0, "R6", "done one cycle after last word", 32'(w), 32'h0);
    check(crcOut == exp, req, "check value", {16'h0, crcOut}, {16'h0, exp});
    check(headerOut == {cnt, exp}, "R4", "header word", headerOut, {cnt, exp});
    @(negedge clk);
    check(!done, "R6", "done single cycle", {31'h0, done}, 32'h0);
    lastExp = exp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !inReady && crcOut == '0 && headerOut == '0, "R11", "reset state",
          {headerOut[31:16], crcOut}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R9: table of blocks, with and without idle gaps
    for (int v = 0; v < NV; v++) begin
      runBlock(VEC_CNT[v], VEC_BASE[v], VEC_GAP[v], VEC_GAP[v] ? "R9" : "R3");
    end

    // R2: one-hot nibble in the top position must differ from the bottom position
    runBlock(16'd1, 32'h1000_0000, 1'b0, "R2");
    check(lastExp == refWord(16'h0, 32'h1000_0000) && lastExp != refWord(16'h0, 32'h0000_0001),
          "R2", "top nibble folded first", {16'h0, lastExp}, {16'h0, refWord(16'h0, 32'h1000_0000)});

    // R7: words offered after completion are ignored
    for (int i = 0; i < 4; i++) begin
      inValid = 1'b1;
      inData = 32'hFFFF_0000 + 32'(i);
      #0.1;
      check(!inReady, "R7", "not ready when idle", {31'h0, inReady}, 32'h0);
      @(negedge clk);
    end
    inValid = 1'b0;
    check(crcOut == lastExp && headerOut == {16'd1, lastExp}, "R7", "result held",
          headerOut, {16'd1, lastExp});

    // R5: empty block
    start = 1'b1;
    wordCount = 16'd0;
    @(negedge clk);
    start = 1'b0;
    check(done && crcOut == 16'h0, "R5", "empty block done", {done, 15'h0, crcOut}, 32'h8000_0000);
    check(headerOut == 32'h0, "R4", "empty header", headerOut, 32'h0);
    @(negedge clk);
    check(!done, "R5", "empty done single", {31'h0, done}, 32'h0);

    // R8: restart in the middle of a block
    start = 1'b1;
    wordCount = 16'd5;
    @(negedge clk);
    start = 1'b0;
    inValid = 1'b1;
    inData = 32'h5555_AAAA;
    @(negedge clk);
    inData = 32'h0F0F_0F0F;
    @(negedge clk);
    inValid = 1'b0;
    runBlock(16'd2, 32'h0BAD_F00D, 1'b0, "R8");

    // R10: speed-map length block
    runBlock(16'h03F1, 32'hC0DE_0001, 1'b0, "R10");
    check(headerOut[31:16] == 16'h03F1, "R10", "length field", {16'h0, headerOut[31:16]}, 32'h03F1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule